// File: doc/BRIEF.md
# Commit-Width Retirement Sequencer

This block decides, in a single cycle, how many of the oldest reorder-buffer entries of the selected thread leave the machine. It looks at a window of head slots, oldest first, and walks them in order. A slot whose result is already discarded leaves for free. A finished instruction retires and uses one unit of commit bandwidth. An instruction that cannot retire yet stops the walk. Unexecuted serializing instructions and uncached loads are handed back to the execute side by sequence number. A faulting instruction raises a trap request.

The walk runs as combinational logic, so the retire, completion and clear strobes act on the ROB at the next clock edge. A small datapath keeps the last retired sequence number, the architectural PC pair and two running counters. The counters are the number of discarded entries drained and the number of cycles that used the full commit width.

Top module: `retire_sequencer`

## Requirements
- R1: The walk visits slots from index 0 upward. It stops at the first slot whose ready bit is low, when the number committed this cycle equals WIDTH, or at once when `threadValid` is low. Only slots visited before the stop may have their retire strobe set. `commitCount` reports the number of non-discarded instructions retired this cycle.
- R2: A ready slot with its squashed bit set gets a retire strobe, does not add to `commitCount` and adds one to `squashRetireTotal` at the clock edge.
- R3: A ready, unexecuted slot flagged non-speculative, barrier or store-conditional always stops the walk. If nothing has committed yet this cycle and `storesPending` is low, it also raises `nonSpecValid`, drives its sequence number on `nonSpecSeq` and sets its `clearCanCommit` bit. Otherwise it raises nothing.
- R4: A ready, unexecuted load slot that is not flagged as in R3 raises `nonSpecValid` and `uncachedLoad`, drives its sequence number and sets its `clearCanCommit` bit, whatever the commit count or `storesPending`. It then stops the walk. Any other unexecuted slot stops the walk silently.
- R5: A ready, executed slot with its fault bit set stops the walk. If nothing has committed yet this cycle and `storesPending` is low, it raises `trapReq` and sets its `complete` bit.
- R6: When at least one instruction commits, at the next edge `doneSeq` takes the sequence number of the last committed slot. `pc` takes that slot's next-PC, and `nextPc` takes that value plus INST_BYTES. With no commit, all three hold.
- R7: `coreInstCount` counts this cycle's commits excluding slots flagged nop or instruction prefetch.
- R8: `fullWidthCycles` increments at each edge where `commitCount` equals WIDTH.
- R9: A committed slot sets its `complete` bit unless it is flagged as a store.
- R10: While `rst` is high, `doneSeq`, `pc`, `nextPc`, `squashRetireTotal` and `fullWidthCycles` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| threadValid | input | 1 | A thread is selected this cycle |
| storesPending | input | 1 | Stores still await writeback |
| headReady | input | SLOTS | Slot holds a ready head entry |
| headSquashed | input | SLOTS | Entry already discarded |
| headExecuted | input | SLOTS | Entry has executed |
| headFault | input | SLOTS | Entry carries a fault |
| headNonSpec | input | SLOTS | Entry must run non-speculatively |
| headBarrier | input | SLOTS | Memory or write barrier |
| headStoreCond | input | SLOTS | Store-conditional |
| headLoad | input | SLOTS | Load |
| headStore | input | SLOTS | Store (completes itself) |
| headNop | input | SLOTS | Nop |
| headPrefetch | input | SLOTS | Instruction prefetch |
| headSeq | input | SLOTS*SEQ_W | Sequence number per slot |
| headNextPc | input | SLOTS*PC_W | Next-PC per slot |
| retire | output | SLOTS | Remove slot from ROB |
| complete | output | SLOTS | Mark slot completed |
| clearCanCommit | output | SLOTS | Clear slot's can-commit bit |
| nonSpecValid | output | 1 | Non-speculative hand-back valid |
| uncachedLoad | output | 1 | Hand-back is an uncached load |
| nonSpecSeq | output | SEQ_W | Sequence number handed back |
| trapReq | output | 1 | Trap request |
| commitCount | output | $clog2(WIDTH+1) | Commits this cycle |
| coreInstCount | output | $clog2(WIDTH+1) | Commits counted for the core |
| doneSeq | output | SEQ_W | Last committed sequence number |
| pc | output | PC_W | Architectural PC |
| nextPc | output | PC_W | Following PC |
| squashRetireTotal | output | STAT_W | Discarded entries drained |
| fullWidthCycles | output | STAT_W | Cycles at full commit width |

## Verification
The hardest case to reach is a discarded entry sitting just past the WIDTH-th commit. The walk must leave it in place, although an earlier discarded entry in the same window was drained. The random generator makes discarded, unready and unexecuted slots dense enough for this to occur. Directed windows also place faults and serializing instructions right after a commit, and under pending stores, so that every stall branch is taken on both sides of its condition.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  localparam int IDX_W = 8;

  // Control-to-datapath strobes for one cycle.
  typedef struct packed {
    logic             advance;   // at least one commit
    logic             fullWidth; // commits == WIDTH
    logic [IDX_W-1:0] lastIdx;   // youngest committed slot
    logic [IDX_W-1:0] sqCnt;     // discarded entries drained
  } ctlStrobe_t;
endpackage

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int WIDTH = 4,
  parameter int SEQ_W = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           threadValid,
  input  logic                           storesPending,
  input  logic [SLOTS-1:0]               headReady,
  input  logic [SLOTS-1:0]               headSquashed,
  input  logic [SLOTS-1:0]               headExecuted,
  input  logic [SLOTS-1:0]               headFault,
  input  logic [SLOTS-1:0]               headNonSpec,
  input  logic [SLOTS-1:0]               headBarrier,
  input  logic [SLOTS-1:0]               headStoreCond,
  input  logic [SLOTS-1:0]               headLoad,
  input  logic [SLOTS-1:0]               headStore,
  input  logic [SLOTS-1:0]               headNop,
  input  logic [SLOTS-1:0]               headPrefetch,
  input  logic [SLOTS*SEQ_W-1:0]         headSeq,
  output logic [SLOTS-1:0]               retire,
  output logic [SLOTS-1:0]               complete,
  output logic [SLOTS-1:0]               clearCanCommit,
  output logic                           nonSpecValid,
  output logic                           uncachedLoad,
  output logic [SEQ_W-1:0]               nonSpecSeq,
  output logic                           trapReq,
  output logic [$clog2(WIDTH+1)-1:0]     commitCount,
  output logic [$clog2(WIDTH+1)-1:0]     coreInstCount,
  output ctlStrobe_t                     ctl
);
  localparam int CW = $clog2(WIDTH+1);
  localparam logic [CW-1:0] WIDTH_C = CW'(WIDTH);

  logic          stop;
  logic [CW-1:0] cnt;
  logic [CW-1:0] coreCnt;
  logic [IDX_W-1:0] sq;
  logic [IDX_W-1:0] last;

  always_comb begin
    stop           = !threadValid;
    cnt            = '0;
    coreCnt        = '0;
    sq             = '0;
    last           = '0;
    retire         = '0;
    complete       = '0;
    clearCanCommit = '0;
    nonSpecValid   = 1'b0;
    uncachedLoad   = 1'b0;
    nonSpecSeq     = '0;
    trapReq        = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!stop) begin
        if (cnt == WIDTH_C || !headReady[i]) begin
          stop = 1'b1;
        end else if (headSquashed[i]) begin
          retire[i] = 1'b1;
          sq        = sq + 1'b1;
        end else if (!headExecuted[i]) begin
          stop = 1'b1;
          if (headNonSpec[i] || headBarrier[i] || headStoreCond[i]) begin
            if (cnt == '0 && !storesPending) begin
              nonSpecValid      = 1'b1;
              nonSpecSeq        = headSeq[i*SEQ_W +: SEQ_W];
              clearCanCommit[i] = 1'b1;
            end
          end else if (headLoad[i]) begin
            nonSpecValid      = 1'b1;
            uncachedLoad      = 1'b1;
            nonSpecSeq        = headSeq[i*SEQ_W +: SEQ_W];
            clearCanCommit[i] = 1'b1;
          end
        end else if (headFault[i]) begin
          stop = 1'b1;
          if (cnt == '0 && !storesPending) begin
            trapReq     = 1'b1;
            complete[i] = 1'b1;
          end
        end else begin
          retire[i]   = 1'b1;
          complete[i] = !headStore[i];
          cnt         = cnt + 1'b1;
          if (!headNop[i] && !headPrefetch[i]) coreCnt = coreCnt + 1'b1;
          last        = IDX_W'(i);
        end
      end
    end
    commitCount    = cnt;
    coreInstCount  = coreCnt;
    ctl.advance    = (cnt != '0);
    ctl.fullWidth  = (cnt == WIDTH_C);
    ctl.lastIdx    = last;
    ctl.sqCnt      = sq;
  end

  p_width_cap_r1: assert property (@(posedge clk) disable iff (rst)
    commitCount <= WIDTH_C);
  p_retire_ready_r1: assert property (@(posedge clk) disable iff (rst)
    (retire & ~headReady) == '0);
  p_idle_thread_r1: assert property (@(posedge clk) disable iff (rst)
    !threadValid |-> (retire == '0 && !trapReq && !nonSpecValid));
  p_nonspec_drained_r3: assert property (@(posedge clk) disable iff (rst)
    (nonSpecValid && !uncachedLoad) |-> (commitCount == '0 && !storesPending));
  p_trap_alone_r5: assert property (@(posedge clk) disable iff (rst)
    trapReq |-> (commitCount == '0 && !storesPending && !nonSpecValid));
  p_core_le_commit_r7: assert property (@(posedge clk) disable iff (rst)
    coreInstCount <= commitCount);
endmodule

// File: rtl/rseq_dpath.sv
module rseq_dpath
  import rseq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int STAT_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctlStrobe_t             ctl,
  input  logic [SLOTS*SEQ_W-1:0] headSeq,
  input  logic [SLOTS*PC_W-1:0]  headNextPc,
  output logic [SEQ_W-1:0]       doneSeq,
  output logic [PC_W-1:0]        pc,
  output logic [PC_W-1:0]        nextPc,
  output logic [STAT_W-1:0]      squashRetireTotal,
  output logic [STAT_W-1:0]      fullWidthCycles
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  logic [SEQ_W-1:0] lastSeq;
  logic [PC_W-1:0]  lastNext;

  always_comb begin
    lastSeq  = headSeq[int'(ctl.lastIdx)*SEQ_W +: SEQ_W];
    lastNext = headNextPc[int'(ctl.lastIdx)*PC_W +: PC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doneSeq           <= '0;
      pc                <= '0;
      nextPc            <= '0;
      squashRetireTotal <= '0;
      fullWidthCycles   <= '0;
    end else begin
      if (ctl.advance) begin
        doneSeq <= lastSeq;
        pc      <= lastNext;
        nextPc  <= lastNext + STEP;
      end
      squashRetireTotal <= squashRetireTotal + STAT_W'(ctl.sqCnt);
      if (ctl.fullWidth) fullWidthCycles <= fullWidthCycles + 1'b1;
    end
  end

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ctl.advance |=> ($stable(doneSeq) && $stable(pc) && $stable(nextPc)));
  p_pc_step_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.advance |=> (nextPc == pc + STEP));
  p_full_count_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.fullWidth |=> (fullWidthCycles == $past(fullWidthCycles) + 1'b1));
endmodule

// File: rtl/retire_sequencer.sv
module retire_sequencer
  import rseq_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int WIDTH      = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int STAT_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       threadValid,
  input  logic                       storesPending,
  input  logic [SLOTS-1:0]           headReady,
  input  logic [SLOTS-1:0]           headSquashed,
  input  logic [SLOTS-1:0]           headExecuted,
  input  logic [SLOTS-1:0]           headFault,
  input  logic [SLOTS-1:0]           headNonSpec,
  input  logic [SLOTS-1:0]           headBarrier,
  input  logic [SLOTS-1:0]           headStoreCond,
  input  logic [SLOTS-1:0]           headLoad,
  input  logic [SLOTS-1:0]           headStore,
  input  logic [SLOTS-1:0]           headNop,
  input  logic [SLOTS-1:0]           headPrefetch,
  input  logic [SLOTS*SEQ_W-1:0]     headSeq,
  input  logic [SLOTS*PC_W-1:0]      headNextPc,
  output logic [SLOTS-1:0]           retire,
  output logic [SLOTS-1:0]           complete,
  output logic [SLOTS-1:0]           clearCanCommit,
  output logic                       nonSpecValid,
  output logic                       uncachedLoad,
  output logic [SEQ_W-1:0]           nonSpecSeq,
  output logic                       trapReq,
  output logic [$clog2(WIDTH+1)-1:0] commitCount,
  output logic [$clog2(WIDTH+1)-1:0] coreInstCount,
  output logic [SEQ_W-1:0]           doneSeq,
  output logic [PC_W-1:0]            pc,
  output logic [PC_W-1:0]            nextPc,
  output logic [STAT_W-1:0]          squashRetireTotal,
  output logic [STAT_W-1:0]          fullWidthCycles
);
  ctlStrobe_t ctl;

  rseq_ctrl #(.SLOTS(SLOTS), .WIDTH(WIDTH), .SEQ_W(SEQ_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .threadValid(threadValid), .storesPending(storesPending),
    .headReady(headReady), .headSquashed(headSquashed),
    .headExecuted(headExecuted), .headFault(headFault),
    .headNonSpec(headNonSpec), .headBarrier(headBarrier),
    .headStoreCond(headStoreCond), .headLoad(headLoad),
    .headStore(headStore), .headNop(headNop), .headPrefetch(headPrefetch),
    .headSeq(headSeq),
    .retire(retire), .complete(complete), .clearCanCommit(clearCanCommit),
    .nonSpecValid(nonSpecValid), .uncachedLoad(uncachedLoad),
    .nonSpecSeq(nonSpecSeq), .trapReq(trapReq),
    .commitCount(commitCount), .coreInstCount(coreInstCount),
    .ctl(ctl)
  );

  rseq_dpath #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .PC_W(PC_W),
               .INST_BYTES(INST_BYTES), .STAT_W(STAT_W)) dpath_i (
    .clk(clk), .rst(rst), .ctl(ctl),
    .headSeq(headSeq), .headNextPc(headNextPc),
    .doneSeq(doneSeq), .pc(pc), .nextPc(nextPc),
    .squashRetireTotal(squashRetireTotal),
    .fullWidthCycles(fullWidthCycles)
  );
endmodule

// File: tb/retire_sequencer_tb_top.sv
module retire_sequencer_tb_top;
  localparam int SLOTS = 8, WIDTH = 4, SEQ_W = 16, PC_W = 32;
  localparam int INST_BYTES = 4, STAT_W = 16;
  localparam int CW = $clog2(WIDTH+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic threadValid, storesPending;
  logic [SLOTS-1:0] hRdy, hSq, hEx, hFlt, hNs, hBar, hSc, hLd, hSt, hNop, hPf;
  logic [SLOTS*SEQ_W-1:0] hSeq;
  logic [SLOTS*PC_W-1:0]  hNpc;
  logic [SLOTS-1:0] retire, complete, clearCanCommit;
  logic nonSpecValid, uncachedLoad, trapReq;
  logic [SEQ_W-1:0] nonSpecSeq, doneSeq;
  logic [CW-1:0] commitCount, coreInstCount;
  logic [PC_W-1:0] pc, nextPc;
  logic [STAT_W-1:0] squashRetireTotal, fullWidthCycles;

  retire_sequencer #(.SLOTS(SLOTS), .WIDTH(WIDTH), .SEQ_W(SEQ_W), .PC_W(PC_W),
    .INST_BYTES(INST_BYTES), .STAT_W(STAT_W)) dut_i (
    .clk(clk), .rst(rst), .threadValid(threadValid), .storesPending(storesPending),
    .headReady(hRdy), .headSquashed(hSq), .headExecuted(hEx), .headFault(hFlt),
    .headNonSpec(hNs), .headBarrier(hBar), .headStoreCond(hSc), .headLoad(hLd),
    .headStore(hSt), .headNop(hNop), .headPrefetch(hPf),
    .headSeq(hSeq), .headNextPc(hNpc),
    .retire(retire), .complete(complete), .clearCanCommit(clearCanCommit),
    .nonSpecValid(nonSpecValid), .uncachedLoad(uncachedLoad),
    .nonSpecSeq(nonSpecSeq), .trapReq(trapReq),
    .commitCount(commitCount), .coreInstCount(coreInstCount),
    .doneSeq(doneSeq), .pc(pc), .nextPc(nextPc),
    .squashRetireTotal(squashRetireTotal), .fullWidthCycles(fullWidthCycles));

  int checks = 0;
  int errors = 0;

  // expected combinational results
  logic [SLOTS-1:0] eRet, eCmp, eClr;
  logic eNsv, eUnc, eTrap;
  logic [SEQ_W-1:0] eNsSeq;
  int eCnt, eCore, eSq, eLast;
  // reference state
  logic [SEQ_W-1:0] mDone;
  logic [PC_W-1:0] mPc, mNext;
  logic [STAT_W-1:0] mSq, mFull;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SEQ_W-1:0] seqOf(int i);
    return hSeq[i*SEQ_W +: SEQ_W];
  endfunction

  task automatic computeExp();
    bit stop;
    stop = !threadValid;
    eRet = '0; eCmp = '0; eClr = '0;
    eNsv = 0; eUnc = 0; eTrap = 0; eNsSeq = '0;
    eCnt = 0; eCore = 0; eSq = 0; eLast = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (stop) continue;
      if (eCnt == WIDTH || !hRdy[i]) stop = 1;
      else if (hSq[i]) begin eRet[i] = 1; eSq++; end
      else if (!hEx[i]) begin
        stop = 1;
        if (hNs[i] || hBar[i] || hSc[i]) begin
          if (eCnt == 0 && !storesPending) begin
            eNsv = 1; eNsSeq = seqOf(i); eClr[i] = 1;
          end
        end else if (hLd[i]) begin
          eNsv = 1; eUnc = 1; eNsSeq = seqOf(i); eClr[i] = 1;
        end
      end else if (hFlt[i]) begin
        stop = 1;
        if (eCnt == 0 && !storesPending) begin eTrap = 1; eCmp[i] = 1; end
      end else begin
        eRet[i] = 1; eCmp[i] = !hSt[i]; eCnt++; eLast = i;
        if (!hNop[i] && !hPf[i]) eCore++;
      end
    end
  endtask

  task automatic clearIn();
    threadValid = 1; storesPending = 0;
    hRdy = '1; hSq = '0; hEx = '1; hFlt = '0; hNs = '0; hBar = '0;
    hSc = '0; hLd = '0; hSt = '0; hNop = '0; hPf = '0;
    for (int i = 0; i < SLOTS; i++) begin
      hSeq[i*SEQ_W +: SEQ_W] = SEQ_W'(16'h100 + i);
      hNpc[i*PC_W +: PC_W]   = PC_W'(32'h1000 + 4*(i+1));
    end
  endtask

  task automatic randIn(int base);
    threadValid   = ($urandom % 10) != 0;
    storesPending = ($urandom % 3) == 0;
    for (int i = 0; i < SLOTS; i++) begin
      hRdy[i] = ($urandom % 9) != 0;
      hSq[i]  = ($urandom % 5) == 0;
      hEx[i]  = ($urandom % 7) != 0;
      hFlt[i] = ($urandom % 10) == 0;
      hNs[i]  = ($urandom % 8) == 0;
      hBar[i] = ($urandom % 15) == 0;
      hSc[i]  = ($urandom % 20) == 0;
      hLd[i]  = ($urandom % 3) == 0;
      hSt[i]  = ($urandom % 4) == 0;
      hNop[i] = ($urandom % 7) == 0;
      hPf[i]  = ($urandom % 12) == 0;
      hSeq[i*SEQ_W +: SEQ_W] = SEQ_W'(base + i);
      hNpc[i*PC_W +: PC_W]   = PC_W'({$urandom} & 32'hFFFF_FFFC);
    end
  endtask

  // Called just after a falling edge with inputs set.
  task automatic step();
    #2;
    computeExp();
    chk("R1", "retire", 64'(retire), 64'(eRet));
    chk("R1", "commitCount", 64'(commitCount), 64'(eCnt));
    chk("R3", "nonSpecValid", 64'(nonSpecValid), 64'(eNsv));
    chk("R3", "nonSpecSeq", 64'(nonSpecSeq), 64'(eNsSeq));
    chk("R3", "clearCanCommit", 64'(clearCanCommit), 64'(eClr));
    chk("R4", "uncachedLoad", 64'(uncachedLoad), 64'(eUnc));
    chk("R5", "trapReq", 64'(trapReq), 64'(eTrap));
    chk("R7", "coreInstCount", 64'(coreInstCount), 64'(eCore));
    chk("R9", "complete", 64'(complete), 64'(eCmp));
    @(posedge clk);
    if (eCnt > 0) begin
      mDone = seqOf(eLast);
      mPc   = hNpc[eLast*PC_W +: PC_W];
      mNext = mPc + PC_W'(INST_BYTES);
    end
    mSq = mSq + STAT_W'(eSq);
    if (eCnt == WIDTH) mFull = mFull + 1'b1;
    #3;
    chk("R6", "doneSeq", 64'(doneSeq), 64'(mDone));
    chk("R6", "pc", 64'(pc), 64'(mPc));
    chk("R6", "nextPc", 64'(nextPc), 64'(mNext));
    chk("R2", "squashRetireTotal", 64'(squashRetireTotal), 64'(mSq));
    chk("R8", "fullWidthCycles", 64'(fullWidthCycles), 64'(mFull));
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    clearIn();
    mDone = '0; mPc = '0; mNext = '0; mSq = '0; mFull = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset values
    chk("R10", "doneSeq", 64'(doneSeq), 0);
    chk("R10", "pc", 64'(pc), 0);
    chk("R10", "nextPc", 64'(nextPc), 0);
    chk("R10", "squashRetireTotal", 64'(squashRetireTotal), 0);
    chk("R10", "fullWidthCycles", 64'(fullWidthCycles), 0);
    rst = 0;

    // R1/R8: all ready and executed, width caps at 4
    clearIn(); step();
    chk("R1", "width cap", 64'(retire), 64'h0F);
    // R2: squashed slots 0 and 2 drain for free
    clearIn(); hSq[0] = 1; hSq[2] = 1; step();
    chk("R2", "drain window", 64'(retire), 64'h3F);
    // R1: squashed head just past the full width stays
    clearIn(); hSq[4] = 1; step();
    // R5: fault first, stores idle -> trap
    clearIn(); hFlt[0] = 1; step();
    // R5: fault first, stores pending -> stall
    clearIn(); hFlt[0] = 1; storesPending = 1; step();
    // R5: fault after one commit -> stall
    clearIn(); hFlt[1] = 1; step();
    // R3: non-speculative first / after commit / under stores
    clearIn(); hEx[0] = 0; hNs[0] = 1; step();
    clearIn(); hEx[1] = 0; hBar[1] = 1; step();
    clearIn(); hEx[0] = 0; hSc[0] = 1; storesPending = 1; step();
    // R4: uncached load after commit with stores pending
    clearIn(); hEx[2] = 0; hLd[2] = 1; storesPending = 1; step();
    // R1: no thread
    clearIn(); threadValid = 0; step();
    // R7/R9: nops, prefetches, stores
    clearIn(); hNop[0] = 1; hPf[2] = 1; hSt[1] = 1; step();
    // R1: unready slot 0
    clearIn(); hRdy[0] = 0; step();

    for (int n = 0; n < 400; n++) begin
      randIn(n * SLOTS);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule